// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the ready queues of an out-of-order core and its execution pipes. Four candidate sources are presented to it every cycle: an integer queue, a floating-point queue, a branch queue and a queue of squashed instructions waiting to be drained. Each source shows a short window of its oldest entries, with entry 0 the oldest and valid entries contiguous from entry 0. Every entry carries a sequence number, and the entries of a window appear in ascending sequence order.

Within one cycle the selector runs a fixed chain of pick steps, one per issue slot. At each step it looks at the current head of every source that may still issue. It picks the head with the smallest sequence number and places it in the next slot. Each of the three instruction classes has its own per-cycle cap. Squashed entries are never held back by a class cap; only the total slot count limits them. A class entry that has been squashed in the meantime carries a kill mark. Such an entry is dropped from its queue without taking a slot.

The selector reports how many entries to remove from each source in the same cycle, so the queues can advance at the clock edge. The chosen slots appear one cycle later on a registered issue port.

Top module: `issue_age_picker`

## Requirements
- R1: The entry issued first in a cycle is the eligible head with the smallest sequence number, and later slots hold each later pick in order, so valid slots carry non-decreasing sequence numbers.
- R2: The integer, floating-point and branch classes each fill at most INT_W, FP_W and BR_W slots per cycle. Once a class reaches its cap, its queue is no longer looked at for the rest of that cycle.
- R3: Entries of the squashed source (source index 3) are eligible at every pick step while slots remain, regardless of the class caps.
- R4: At most TOTAL_W slots are filled per cycle. Filled slots are contiguous from slot 0, and selection ends early when no eligible candidate remains.
- R5: A class entry whose kill bit is set is discarded without taking a slot, and it is counted in that source's pop count. This happens only when a pick step examines that class while the class is below its cap.
- R6: Equal sequence numbers are resolved in the source order integer, floating point, branch, squashed.
- R7: pop_cnt gives, combinationally and in the same cycle as the inputs, the number of entries each source consumed (issued plus discarded). Source s occupies bits [s*PW +: PW], where PW = clog2(LOOK+1).
- R8: While reset is asserted, and after it, no slot is valid until a pick is made. A slot that is not filled in a cycle shows valid 0.
- R9: Picks appear on slot_vld/slot_cls/slot_seq after the next rising clock edge. The class tag is 0 for integer, 1 for floating point, 2 for branch and 3 for squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_vld | input | 4*LOOK | Entry valid; source s entry j at bit s*LOOK+j (sources 0 int, 1 fp, 2 branch, 3 squashed) |
| cls_kill | input | 3*LOOK | Kill mark for class entries; class c entry j at bit c*LOOK+j |
| src_seq | input | 4*LOOK*SEQ_W | Sequence numbers; source s entry j at [(s*LOOK+j)*SEQ_W +: SEQ_W] |
| pop_cnt | output | 4*PW | Entries consumed per source this cycle |
| slot_vld | output | TOTAL_W | Registered slot valid |
| slot_cls | output | 2*TOTAL_W | Registered class tag per slot |
| slot_seq | output | TOTAL_W*SEQ_W | Registered sequence number per slot |

## Verification
A wrong pointer inside the pick chain shows up as a pop count that differs from the entries consumed, and this is visible on pop_cnt before the same clock edge. A wrong class counter or a wrong age comparison shows up one edge later. The symptom is a slot holding a younger entry than an eligible older one, a class filling more slots than its cap, or a squashed entry held back by a full class. The stimulus uses windows in which killed entries, exhausted caps and equal sequence numbers meet one another, so that each of these errors changes at least one port value.

// File: rtl/iap_pkg.sv
package iap_pkg;
  localparam int NSRC = 4;
  localparam int NCLS = 3;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_FP  = 2'd1,
    SRC_BR  = 2'd2,
    SRC_SQ  = 2'd3
  } src_e;
endpackage

// File: rtl/iap_head_scan.sv
module iap_head_scan #(
  parameter int LOOK  = 2,
  parameter int SEQ_W = 8,
  parameter int PW    = $clog2(LOOK + 1)
) (
  input  logic [LOOK-1:0]       vld_i,
  input  logic [LOOK-1:0]       kill_i,
  input  logic [LOOK*SEQ_W-1:0] seq_i,
  input  logic [PW-1:0]         ptr_i,
  output logic                  found_o,
  output logic [PW-1:0]         idx_o,
  output logic [SEQ_W-1:0]      seq_o,
  output logic [PW-1:0]         skip_o
);
  // First live entry at or after the pointer; skip_o is where the
  // consumed region ends once leading killed entries are dropped.
  always_comb begin
    logic stop;
    stop    = 1'b0;
    found_o = 1'b0;
    idx_o   = ptr_i;
    seq_o   = '0;
    skip_o  = ptr_i;
    for (int j = 0; j < LOOK; j++) begin
      if (!stop && (PW'(j) >= ptr_i)) begin
        if (!vld_i[j]) begin
          stop = 1'b1;
        end else if (!kill_i[j]) begin
          found_o = 1'b1;
          idx_o   = PW'(j);
          seq_o   = seq_i[j*SEQ_W +: SEQ_W];
          stop    = 1'b1;
        end else begin
          skip_o = PW'(j + 1);
        end
      end
    end
  end
endmodule

// File: rtl/iap_age_min.sv
module iap_age_min
  import iap_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic [NSRC-1:0]       cand_i,
  input  logic [NSRC*SEQ_W-1:0] seq_i,
  output logic                  any_o,
  output logic [1:0]            win_o,
  output logic [SEQ_W-1:0]      seq_o
);
  // Strict less-than keeps the lower source index on equal numbers.
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    seq_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && (!any_o || (seq_i[i*SEQ_W +: SEQ_W] < seq_o))) begin
        any_o = 1'b1;
        win_o = 2'(i);
        seq_o = seq_i[i*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/iap_pick_stage.sv
module iap_pick_stage
  import iap_pkg::*;
#(
  parameter int INT_W = 1,
  parameter int FP_W  = 1,
  parameter int BR_W  = 1,
  parameter int LOOK  = 2,
  parameter int SEQ_W = 8,
  parameter int PW    = 2,
  parameter int CW    = 1
) (
  input  logic                       en_i,
  input  logic [NSRC*PW-1:0]         ptr_i,
  input  logic [NCLS*CW-1:0]         cnt_i,
  input  logic [NSRC*LOOK-1:0]       vld_i,
  input  logic [NCLS*LOOK-1:0]       kill_i,
  input  logic [NSRC*LOOK*SEQ_W-1:0] seq_i,
  output logic                       en_o,
  output logic [NSRC*PW-1:0]         ptr_o,
  output logic [NCLS*CW-1:0]         cnt_o,
  output logic                       pick_vld_o,
  output logic [1:0]                 pick_cls_o,
  output logic [SEQ_W-1:0]           pick_seq_o
);
  localparam int CAP [NCLS] = '{INT_W, FP_W, BR_W};

  logic [NSRC-1:0]       elig;
  logic [NSRC-1:0]       found;
  logic [NSRC-1:0]       cand;
  logic [PW-1:0]         idx  [NSRC];
  logic [PW-1:0]         skip [NSRC];
  logic [NSRC*SEQ_W-1:0] hseq;
  logic                  any;
  logic [1:0]            win;
  logic [SEQ_W-1:0]      wseq;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [LOOK-1:0] kill_s;
    if (s < NCLS) begin : g_cls
      assign kill_s  = kill_i[s*LOOK +: LOOK];
      assign elig[s] = en_i && (int'(cnt_i[s*CW +: CW]) < CAP[s]);
    end else begin : g_sq
      assign kill_s  = '0;
      assign elig[s] = en_i;
    end

    iap_head_scan #(.LOOK(LOOK), .SEQ_W(SEQ_W), .PW(PW)) i_scan (
      .vld_i   (vld_i[s*LOOK +: LOOK]),
      .kill_i  (kill_s),
      .seq_i   (seq_i[s*LOOK*SEQ_W +: LOOK*SEQ_W]),
      .ptr_i   (ptr_i[s*PW +: PW]),
      .found_o (found[s]),
      .idx_o   (idx[s]),
      .seq_o   (hseq[s*SEQ_W +: SEQ_W]),
      .skip_o  (skip[s])
    );

    assign cand[s] = elig[s] & found[s];
  end

  iap_age_min #(.SEQ_W(SEQ_W)) i_min (
    .cand_i (cand),
    .seq_i  (hseq),
    .any_o  (any),
    .win_o  (win),
    .seq_o  (wseq)
  );

  always_comb begin
    en_o       = en_i & any;
    pick_vld_o = any;
    pick_cls_o = win;
    pick_seq_o = wseq;
    ptr_o      = ptr_i;
    cnt_o      = cnt_i;
    for (int s = 0; s < NSRC; s++) begin
      if (elig[s]) begin
        if (any && (win == 2'(s))) begin
          ptr_o[s*PW +: PW] = idx[s] + PW'(1);
        end else begin
          ptr_o[s*PW +: PW] = skip[s];
        end
      end
    end
    for (int c = 0; c < NCLS; c++) begin
      if (any && (win == 2'(c))) begin
        cnt_o[c*CW +: CW] = cnt_i[c*CW +: CW] + CW'(1);
      end
    end
  end
endmodule

// File: rtl/issue_age_picker.sv
module issue_age_picker
  import iap_pkg::*;
#(
  parameter int TOTAL_W = 1,
  parameter int INT_W   = 1,
  parameter int FP_W    = 1,
  parameter int BR_W    = 1,
  parameter int LOOK    = 2,
  parameter int SEQ_W   = 8,
  localparam int PW     = $clog2(LOOK + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC*LOOK-1:0]       src_vld,
  input  logic [NCLS*LOOK-1:0]       cls_kill,
  input  logic [NSRC*LOOK*SEQ_W-1:0] src_seq,
  output logic [NSRC*PW-1:0]         pop_cnt,
  output logic [TOTAL_W-1:0]         slot_vld,
  output logic [TOTAL_W*2-1:0]       slot_cls,
  output logic [TOTAL_W*SEQ_W-1:0]   slot_seq
);
  localparam int CW = $clog2(TOTAL_W + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // Pick chain, one stage per issue slot.
  logic [TOTAL_W:0]          en_c;
  logic [NSRC*PW-1:0]        ptr_c [TOTAL_W+1];
  logic [NCLS*CW-1:0]        cnt_c [TOTAL_W+1];
  logic [TOTAL_W-1:0]        pick_vld;
  logic [TOTAL_W*2-1:0]      pick_cls;
  logic [TOTAL_W*SEQ_W-1:0]  pick_seq;

  assign en_c[0]  = 1'b1;
  assign ptr_c[0] = '0;
  assign cnt_c[0] = '0;

  for (genvar k = 0; k < TOTAL_W; k++) begin : g_stage
    iap_pick_stage #(
      .INT_W(INT_W), .FP_W(FP_W), .BR_W(BR_W),
      .LOOK(LOOK), .SEQ_W(SEQ_W), .PW(PW), .CW(CW)
    ) i_stage (
      .en_i       (en_c[k]),
      .ptr_i      (ptr_c[k]),
      .cnt_i      (cnt_c[k]),
      .vld_i      (src_vld),
      .kill_i     (cls_kill),
      .seq_i      (src_seq),
      .en_o       (en_c[k+1]),
      .ptr_o      (ptr_c[k+1]),
      .cnt_o      (cnt_c[k+1]),
      .pick_vld_o (pick_vld[k]),
      .pick_cls_o (pick_cls[k*2 +: 2]),
      .pick_seq_o (pick_seq[k*SEQ_W +: SEQ_W])
    );
  end

  assign pop_cnt = ptr_c[TOTAL_W];

  // Issue register: next-state and enables, then the flops.
  logic [TOTAL_W-1:0]         vld_q;
  logic [TOTAL_W*2-1:0]       cls_q;
  logic [TOTAL_W*SEQ_W-1:0]   seq_q;
  logic [TOTAL_W-1:0]         vld_en;
  logic [TOTAL_W-1:0]         dat_en;

  always_comb begin
    vld_en = pick_vld | vld_q;
    dat_en = pick_vld;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      vld_q <= '0;
    end else begin
      for (int k = 0; k < TOTAL_W; k++) begin
        if (vld_en[k]) vld_q[k] <= pick_vld[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < TOTAL_W; k++) begin
      if (dat_en[k]) begin
        cls_q[k*2 +: 2]         <= pick_cls[k*2 +: 2];
        seq_q[k*SEQ_W +: SEQ_W] <= pick_seq[k*SEQ_W +: SEQ_W];
      end
    end
  end

  assign slot_vld = vld_q;
  assign slot_cls = cls_q;
  assign slot_seq = seq_q;
endmodule

// File: rtl/iap_checker.sv
module iap_checker
  import iap_pkg::*;
#(
  parameter int TOTAL_W = 1,
  parameter int INT_W   = 1,
  parameter int FP_W    = 1,
  parameter int BR_W    = 1,
  parameter int LOOK    = 2,
  parameter int SEQ_W   = 8
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [NSRC*$clog2(LOOK+1)-1:0]         pop_cnt,
  input logic [TOTAL_W-1:0]                     slot_vld,
  input logic [TOTAL_W*2-1:0]                   slot_cls,
  input logic [TOTAL_W*SEQ_W-1:0]               slot_seq
);
  localparam int PW = $clog2(LOOK + 1);
  localparam int CAP [NCLS] = '{INT_W, FP_W, BR_W};

  function automatic int cls_cnt(input logic [TOTAL_W-1:0] v,
                                 input logic [TOTAL_W*2-1:0] c, input int s);
    int n;
    n = 0;
    for (int k = 0; k < TOTAL_W; k++) begin
      if (v[k] && (c[k*2 +: 2] == 2'(s))) n++;
    end
    return n;
  endfunction

  // R4: filled slots form a prefix starting at slot 0
  a_r4_slot_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_vld & (slot_vld + 1'b1)) == '0));

  // R1: pick order follows age
  for (genvar k = 0; k + 1 < TOTAL_W; k++) begin : g_age
    a_r1_age_order: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[k+1] |-> (slot_seq[k*SEQ_W +: SEQ_W] <= slot_seq[(k+1)*SEQ_W +: SEQ_W]));
  end

  // R2: per-class cap on registered slots
  for (genvar c = 0; c < NCLS; c++) begin : g_cap
    a_r2_class_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cls_cnt(slot_vld, slot_cls, c) <= CAP[c]);
  end

  // R7: every issued slot was covered by a pop from its source
  for (genvar s = 0; s < NSRC; s++) begin : g_pop
    a_r7_pop_covers: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cls_cnt(slot_vld, slot_cls, s) <= int'($past(pop_cnt[s*PW +: PW]))));
  end
endmodule

bind issue_age_picker iap_checker #(
  .TOTAL_W(TOTAL_W), .INT_W(INT_W), .FP_W(FP_W), .BR_W(BR_W),
  .LOOK(LOOK), .SEQ_W(SEQ_W)
) i_iap_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .pop_cnt  (pop_cnt),
  .slot_vld (slot_vld),
  .slot_cls (slot_cls),
  .slot_seq (slot_seq)
);

// File: tb/test_issue_age_picker.sv
module test_issue_age_picker;
  localparam int TW = 3;
  localparam int LK = 3;
  localparam int SW = 8;
  localparam int PW = 2;

  logic              clk;
  logic              rst_n;
  logic [4*LK-1:0]   src_vld;
  logic [3*LK-1:0]   cls_kill;
  logic [4*LK*SW-1:0] src_seq;
  logic [4*PW-1:0]   pop_cnt;
  logic [TW-1:0]     slot_vld;
  logic [TW*2-1:0]   slot_cls;
  logic [TW*SW-1:0]  slot_seq;

  issue_age_picker #(
    .TOTAL_W(TW), .INT_W(2), .FP_W(1), .BR_W(1), .LOOK(LK), .SEQ_W(SW)
  ) i_issue_age_picker (
    .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .cls_kill(cls_kill),
    .src_seq(src_seq), .pop_cnt(pop_cnt), .slot_vld(slot_vld),
    .slot_cls(slot_cls), .slot_seq(slot_seq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  ni, nf, nb, ns;   // valid entry counts
    logic [2:0]  ki, kf, kb;       // kill masks, bit j = entry j
    logic [23:0] si, sf, sb, ss;   // {e2,e1,e0}
    logic [1:0]  pi, pf, pb, ps;   // expected pops
    logic [2:0]  ev;               // expected slot valid
    logic [5:0]  ec;               // {c2,c1,c0}
    logic [23:0] es;               // {s2,s1,s0}
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    // V0 empty: R4/R8 nothing issues
    '{ni:0,nf:0,nb:0,ns:0,ki:0,kf:0,kb:0,si:0,sf:0,sb:0,ss:0,
      pi:0,pf:0,pb:0,ps:0,ev:3'b000,ec:0,es:0},
    // V1 R1 mixed ages across classes
    '{ni:3,nf:2,nb:1,ns:0,ki:0,kf:0,kb:0,
      si:{8'd9,8'd7,8'd5},sf:{8'd0,8'd8,8'd6},sb:{8'd0,8'd0,8'd2},ss:0,
      pi:1,pf:1,pb:1,ps:0,ev:3'b111,ec:{2'd1,2'd0,2'd2},es:{8'd6,8'd5,8'd2}},
    // V2 R5 killed heads, R2 int cap, R3 squashed fills last slot
    '{ni:3,nf:0,nb:1,ns:1,ki:3'b001,kf:0,kb:3'b001,
      si:{8'd10,8'd4,8'd3},sf:0,sb:{8'd0,8'd0,8'd1},ss:{8'd0,8'd0,8'd20},
      pi:3,pf:0,pb:1,ps:1,ev:3'b111,ec:{2'd3,2'd0,2'd0},es:{8'd20,8'd10,8'd4}},
    // V3 R3 squashed bypasses caps, R2 fp cap
    '{ni:0,nf:3,nb:0,ns:3,ki:0,kf:0,kb:0,
      si:0,sf:{8'd3,8'd2,8'd1},sb:0,ss:{8'd6,8'd5,8'd4},
      pi:0,pf:1,pb:0,ps:2,ev:3'b111,ec:{2'd3,2'd3,2'd1},es:{8'd5,8'd4,8'd1}},
    // V4 R6 equal sequence numbers
    '{ni:1,nf:1,nb:1,ns:1,ki:0,kf:0,kb:0,
      si:{8'd0,8'd0,8'd7},sf:{8'd0,8'd0,8'd7},sb:{8'd0,8'd0,8'd7},ss:{8'd0,8'd0,8'd7},
      pi:1,pf:1,pb:1,ps:0,ev:3'b111,ec:{2'd2,2'd1,2'd0},es:{8'd7,8'd7,8'd7}},
    // V5 R2/R4 int cap stops selection early
    '{ni:3,nf:0,nb:0,ns:0,ki:0,kf:0,kb:0,
      si:{8'd3,8'd2,8'd1},sf:0,sb:0,ss:0,
      pi:2,pf:0,pb:0,ps:0,ev:3'b011,ec:{2'd0,2'd0,2'd0},es:{8'd0,8'd2,8'd1}},
    // V6 R5 all-killed window drained with no slot
    '{ni:2,nf:0,nb:0,ns:0,ki:3'b011,kf:0,kb:0,
      si:{8'd0,8'd2,8'd1},sf:0,sb:0,ss:0,
      pi:2,pf:0,pb:0,ps:0,ev:3'b000,ec:0,es:0},
    // V7 R5 killed branch head dropped while int issues
    '{ni:2,nf:1,nb:2,ns:0,ki:0,kf:0,kb:3'b001,
      si:{8'd0,8'd2,8'd1},sf:{8'd0,8'd0,8'd3},sb:{8'd0,8'd5,8'd4},ss:0,
      pi:2,pf:1,pb:1,ps:0,ev:3'b111,ec:{2'd1,2'd0,2'd0},es:{8'd3,8'd2,8'd1}}
  };

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    logic [1:0] n [4];
    logic [23:0] s [4];
    n[0] = v.ni; n[1] = v.nf; n[2] = v.nb; n[3] = v.ns;
    s[0] = v.si; s[1] = v.sf; s[2] = v.sb; s[3] = v.ss;
    for (int q = 0; q < 4; q++) begin
      for (int j = 0; j < LK; j++) begin
        src_vld[q*LK+j] = (j < int'(n[q]));
        src_seq[(q*LK+j)*SW +: SW] = s[q][j*8 +: 8];
      end
    end
    cls_kill = {v.kb, v.kf, v.ki};
  endtask

  task automatic run_vec(input int i, input vec_t v);
    @(negedge clk);
    drive(v);
    #2;
    // R7: pops visible before the edge
    chk($sformatf("R7 v%0d pop int", i), int'(pop_cnt[0*PW +: PW]), int'(v.pi));
    chk($sformatf("R7 v%0d pop fp",  i), int'(pop_cnt[1*PW +: PW]), int'(v.pf));
    chk($sformatf("R5 v%0d pop br",  i), int'(pop_cnt[2*PW +: PW]), int'(v.pb));
    chk($sformatf("R3 v%0d pop sq",  i), int'(pop_cnt[3*PW +: PW]), int'(v.ps));
    @(posedge clk);
    #1;
    // R9: slots after the edge
    for (int k = 0; k < TW; k++) begin
      chk($sformatf("R4 v%0d slot%0d vld", i, k), int'(slot_vld[k]), int'(v.ev[k]));
      if (v.ev[k]) begin
        chk($sformatf("R9 v%0d slot%0d cls", i, k), int'(slot_cls[k*2 +: 2]), int'(v.ec[k*2 +: 2]));
        chk($sformatf("R1 v%0d slot%0d seq", i, k), int'(slot_seq[k*SW +: SW]), int'(v.es[k*8 +: 8]));
      end
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    src_vld  = '0;
    cls_kill = '0;
    src_seq  = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset slot_vld", int'(slot_vld), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i, VT[i]);

    // R6 tie again after a mixed cycle: back-to-back stream
    run_vec(40, VT[4]);

    // R8: reset in the middle of issue clears slots at once
    @(negedge clk);
    drive(VT[1]);
    @(posedge clk);
    #1;
    chk("R8 slots full before reset", int'(slot_vld), 7);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 slots cleared by reset", int'(slot_vld), 0);
    @(posedge clk);
    #1;
    chk("R8 slots held cleared", int'(slot_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_vec(50, VT[2]);

    // R8: empty inputs leave every slot invalid on the next edge
    run_vec(60, VT[0]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule